// File: doc/BRIEF.md
# Fixed-Latency Line Fill Responder

This block stands in for backing memory behind a cache's line-refill port. The cache sends line-sized requests that can read, write, or do both. A write lands in a small internal word memory on the edge that accepts it and is never answered. A read copies the addressed words out of memory on the edge that accepts it. It then waits in a pending table while its own countdown runs down from a fixed latency.

A finished read is handed back as one fill response carrying the original request address and the copied line. The response goes out only in a cycle where the cache raises its fill-accept input. Several reads can be in flight at once. Because every read waits the same number of cycles, they finish in arrival order, and the oldest finished read always goes first. The pending table has a fixed number of slots. While it is full, a `full` flag is raised and any new read is dropped.

Request length is given in bytes. The number of words moved is that length divided by four, clamped to the line width. Word i of a request lives at memory word (address/4 + i).

Top module: `fill_responder`

## Requirements
- R1: A read accepted on a clock edge becomes ready exactly LATENCY (default 10) edges later. With `fill_accept` held high, `fill_valid` is low in the cycle after the (LATENCY-1)th following edge and high in the cycle after the LATENCY-th.
- R2: `fill_valid` is high only while `fill_accept` is high and a ready read is pending. The read that is presented is removed on that edge. A ready read waits without limit while `fill_accept` is low.
- R3: Whenever `fill_valid` is low, `fill_addr` and `fill_line` are all zeros.
- R4: When several reads are ready, they are returned one per cycle, oldest accepted first.
- R5: A request moves n = min(`req_size`/4, LINE_WORDS) words. Word i sits at memory word (`req_addr`[ADDR_W-1:2] + i) mod MEM_WORDS, and the two low address bits are ignored. Word i occupies `req_line`/`fill_line` bits [32i+31:32i]. Words at i >= n are not written, and they are returned as zero.
- R6: Read data is the memory content at the edge that accepts the read. Writes accepted afterwards do not alter it.
- R7: A write request stores its words on the accepting edge, so a read accepted on the next edge sees them. A write never produces a fill response.
- R8: A request with both `req_rd` and `req_wr` high performs both actions. The read returns the contents from before that same request's write.
- R9: `full` is high while DEPTH (default 4) reads are pending. A read presented while `full` is high creates no entry and is never answered, but the write half of that request is still performed.
- R10: Asserting `rst_n` low empties the pending table and drives `fill_valid`, `fill_addr`, `fill_line` and `full` to zero. Memory contents survive reset.
- R11: `fill_addr` returns the read's full request address, including its low two bits, in the same cycle as `fill_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_rd | input | 1 | The request reads a line |
| req_wr | input | 1 | The request writes a line |
| req_addr | input | ADDR_W | Byte address of word 0 |
| req_size | input | SIZE_W | Request length in bytes |
| req_line | input | LINE_W | Write data, word i at bits 32i upward |
| fill_accept | input | 1 | The cache can take a fill response this cycle |
| fill_valid | output | 1 | A fill response is presented |
| fill_addr | output | ADDR_W | Address of the read being answered |
| fill_line | output | LINE_W | Line data captured when the read was accepted |
| full | output | 1 | The pending table has no free slot |

## Verification
Several properties hold on every cycle and are checked that way. The head entry is ready whenever any entry is ready. The head's countdown falls by one per cycle until it reaches zero. The occupancy count matches the number of live slots and never exceeds DEPTH. A full table stays full unless a response leaves it, and a response with no new read shrinks the table by one. Other behaviours can only be shown by the bench's scenarios against a memory model: the exact latency, clearing of unused words, capture at acceptance versus later writes, address wrap, and writes that still land while a read is dropped.

// File: rtl/fill_pkg.sv
`timescale 1ns/1ps
package fill_pkg;
  localparam int WORD_BITS  = 32;
  localparam int WORD_BYTES = 4;
  typedef logic [WORD_BITS-1:0] word_t;
endpackage

// File: rtl/fill_store.sv
`timescale 1ns/1ps
module fill_store
  import fill_pkg::*;
#(
  parameter  int LINE_WORDS = 4,
  parameter  int MEM_WORDS  = 64,
  localparam int MEM_AW     = $clog2(MEM_WORDS),
  localparam int LINE_W     = LINE_WORDS * WORD_BITS
) (
  input  logic              clk,
  input  logic [MEM_AW-1:0] word_addr,
  input  logic [LINE_WORDS-1:0] word_en,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  output logic [LINE_W-1:0] rd_line
);
  word_t             mem [MEM_WORDS];
  logic [MEM_AW-1:0] idx [LINE_WORDS];

  // Lane addresses wrap modulo the memory size (power of two).
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_lane
    assign idx[w] = word_addr + MEM_AW'(w);
    always_comb rd_line[w*WORD_BITS +: WORD_BITS] = word_en[w] ? mem[idx[w]] : '0;
  end

  // Memory has no reset: its contents survive a reset of the control path.
  always_ff @(posedge clk) begin
    for (int w = 0; w < LINE_WORDS; w++) begin
      if (wr_en && word_en[w]) mem[idx[w]] <= wr_line[w*WORD_BITS +: WORD_BITS];
    end
  end
endmodule

// File: rtl/fill_pending.sv
`timescale 1ns/1ps
module fill_pending
  import fill_pkg::*;
#(
  parameter  int DEPTH   = 4,
  parameter  int LATENCY = 10,
  parameter  int ADDR_W  = 16,
  parameter  int LINE_W  = 128,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W   = $clog2(DEPTH + 1),
  localparam int CNT_W   = (LATENCY > 0) ? $clog2(LATENCY + 1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [LINE_W-1:0] push_line,
  input  logic              pop_req,
  output logic              head_ready,
  output logic [ADDR_W-1:0] head_addr,
  output logic [LINE_W-1:0] head_line,
  output logic              full
);
  typedef logic [PTR_W-1:0] ptr_t;
  typedef logic [CNT_W-1:0] cnt_t;

  logic [DEPTH-1:0] vld_q, vld_d;
  cnt_t             cnt_q [DEPTH];
  cnt_t             cnt_d [DEPTH];
  ptr_t             head_q, head_d, tail_q, tail_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [LINE_W-1:0] line_q [DEPTH];
  logic             do_push, do_pop;
  cnt_t             head_cnt;

  function automatic ptr_t bump(input ptr_t p);
    return (p == ptr_t'(DEPTH - 1)) ? '0 : p + ptr_t'(1);
  endfunction

  assign full       = (occ_q == OCC_W'(DEPTH));
  assign head_cnt   = cnt_q[head_q];
  assign head_ready = vld_q[head_q] && (head_cnt == '0);
  assign head_addr  = addr_q[head_q];
  assign head_line  = line_q[head_q];
  assign do_push    = push_req && !full;
  assign do_pop     = pop_req && head_ready;

  always_comb begin
    vld_d  = vld_q;
    head_d = head_q;
    tail_d = tail_q;
    occ_d  = occ_q;
    for (int e = 0; e < DEPTH; e++) begin
      cnt_d[e] = (vld_q[e] && cnt_q[e] != '0) ? cnt_q[e] - cnt_t'(1) : cnt_q[e];
    end
    if (do_pop) begin
      vld_d[head_q] = 1'b0;
      head_d        = bump(head_q);
    end
    if (do_push) begin
      vld_d[tail_q] = 1'b1;
      cnt_d[tail_q] = cnt_t'(LATENCY);
      tail_d        = bump(tail_q);
    end
    case ({do_push, do_pop})
      2'b10:   occ_d = occ_q + OCC_W'(1);
      2'b01:   occ_d = occ_q - OCC_W'(1);
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
      for (int e = 0; e < DEPTH; e++) cnt_q[e] <= '0;
    end else begin
      vld_q  <= vld_d;
      head_q <= head_d;
      tail_q <= tail_d;
      occ_q  <= occ_d;
      for (int e = 0; e < DEPTH; e++) cnt_q[e] <= cnt_d[e];
    end
  end

  // Payload slots carry no reset; written only when a read is admitted.
  always_ff @(posedge clk) begin
    if (do_push) begin
      addr_q[tail_q] <= push_addr;
      line_q[tail_q] <= push_line;
    end
  end

  logic any_ready;
  always_comb begin
    any_ready = 1'b0;
    for (int e = 0; e < DEPTH; e++) if (vld_q[e] && cnt_q[e] == '0) any_ready = 1'b1;
  end

  assert_oldest_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_ready |-> head_ready);

  assert_countdown_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q[head_q] && head_cnt != '0) |=> (head_cnt == $past(head_cnt) - cnt_t'(1)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q <= OCC_W'(DEPTH)) && ($countones(vld_q) == int'(occ_q)));

  assert_full_drops_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !do_pop) |=> full);

  assert_pop_removes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push) |=> (occ_q == $past(occ_q) - OCC_W'(1)));
endmodule

// File: rtl/fill_responder.sv
`timescale 1ns/1ps
module fill_responder
  import fill_pkg::*;
#(
  parameter  int ADDR_W     = 16,
  parameter  int LINE_WORDS = 4,
  parameter  int MEM_WORDS  = 64,
  parameter  int DEPTH      = 4,
  parameter  int LATENCY    = 10,
  localparam int LINE_W     = LINE_WORDS * WORD_BITS,
  localparam int SIZE_W     = $clog2(LINE_WORDS * WORD_BYTES) + 1,
  localparam int BYTE_SH    = $clog2(WORD_BYTES),
  localparam int MEM_AW     = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [LINE_W-1:0] req_line,
  input  logic              fill_accept,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [LINE_W-1:0] fill_line,
  output logic              full
);
  logic [SIZE_W-1:0]     req_words;
  logic [LINE_WORDS-1:0] word_en;
  logic [LINE_W-1:0]     mem_line;
  logic                  head_ready;
  logic [ADDR_W-1:0]     head_addr;
  logic [LINE_W-1:0]     head_line;

  // Lanes beyond the requested length are masked; longer sizes clamp.
  assign req_words = req_size >> BYTE_SH;
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_en
    assign word_en[w] = (32'(w) < 32'(req_words));
  end

  fill_store #(
    .LINE_WORDS (LINE_WORDS),
    .MEM_WORDS  (MEM_WORDS)
  ) u_store (
    .clk       (clk),
    .word_addr (req_addr[BYTE_SH +: MEM_AW]),
    .word_en   (word_en),
    .wr_en     (req_valid && req_wr),
    .wr_line   (req_line),
    .rd_line   (mem_line)
  );

  fill_pending #(
    .DEPTH   (DEPTH),
    .LATENCY (LATENCY),
    .ADDR_W  (ADDR_W),
    .LINE_W  (LINE_W)
  ) u_pending (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (req_valid && req_rd),
    .push_addr  (req_addr),
    .push_line  (mem_line),
    .pop_req    (fill_accept),
    .head_ready (head_ready),
    .head_addr  (head_addr),
    .head_line  (head_line),
    .full       (full)
  );

  assign fill_valid = fill_accept && head_ready;
  assign fill_addr  = fill_valid ? head_addr : '0;
  assign fill_line  = fill_valid ? head_line : '0;
endmodule

// File: tb/tb_fill_responder.sv
`timescale 1ns/1ps
module tb_fill_responder;
  localparam int LAT = 10;
  localparam int DEP = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, req_valid, req_rd, req_wr, fill_accept;
  logic [15:0]  req_addr;
  logic [4:0]   req_size;
  logic [127:0] req_line;
  logic         fill_valid, full;
  logic [15:0]  fill_addr;
  logic [127:0] fill_line;

  fill_responder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(req_addr), .req_size(req_size), .req_line(req_line), .fill_accept(fill_accept),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_line(fill_line), .full(full)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  logic [31:0] mdl [64];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic int nwords(input int sz);
    int n = sz / 4;
    return (n > 4) ? 4 : n;
  endfunction

  function automatic logic [127:0] model_line(input logic [15:0] a, input int sz);
    logic [127:0] l = '0;
    for (int i = 0; i < nwords(sz); i++) l[i*32 +: 32] = mdl[((a >> 2) + i) & 63];
    return l;
  endfunction

  function automatic logic [127:0] pat(input int seed);
    logic [127:0] l;
    for (int i = 0; i < 4; i++) l[i*32 +: 32] = (32'(seed) * 32'h9E3779B1) ^ (32'(i) << 28) ^ 32'h5A5A;
    return l;
  endfunction

  task automatic issue(input bit rd, input bit wr, input logic [15:0] a, input int sz,
                       input logic [127:0] ln, output logic [127:0] cap);
    cap = model_line(a, sz);
    req_valid = 1'b1; req_rd = rd; req_wr = wr; req_addr = a; req_size = 5'(sz); req_line = ln;
    tick;
    req_valid = 1'b0; req_rd = 1'b0; req_wr = 1'b0; req_addr = '0; req_size = '0; req_line = '0;
    if (wr) for (int i = 0; i < nwords(sz); i++) mdl[((a >> 2) + i) & 63] = ln[i*32 +: 32];
  endtask

  task automatic expect_resp(input logic [15:0] a, input logic [127:0] ln, input string rq);
    int n = 0;
    #1;
    while (!fill_valid && n < LAT + 4) begin tick; n++; end
    chk(fill_valid, rq, "response valid", 128'(fill_valid), 128'(1));
    chk(fill_addr == a, rq, "response address", 128'(fill_addr), 128'(a));
    chk(fill_line == ln, rq, "response line", fill_line, ln);
    tick;
  endtask

  task automatic quiet_for(input int n, input string rq);
    bit ok = 1'b1;
    logic [127:0] seen = '0;
    for (int i = 0; i < n; i++) begin
      tick;
      if (fill_valid || fill_addr != '0 || fill_line != '0) begin
        ok = 1'b0; seen = {fill_line[110:0], fill_valid, fill_addr};
      end
    end
    chk(ok, rq, "no response and zero outputs", seen, '0);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] cap, cap2, junk;
    logic [15:0]  ad [5];
    rst_n = 1'b0; req_valid = 0; req_rd = 0; req_wr = 0; req_addr = '0; req_size = '0;
    req_line = '0; fill_accept = 1'b0;
    tick; tick;
    // R10 / R3: reset state
    chk(!fill_valid && fill_addr == 0 && fill_line == 0, "R10", "outputs in reset",
        {fill_line[110:0], fill_valid, fill_addr}, '0);
    chk(!full, "R10", "full in reset", 128'(full), '0);
    rst_n = 1'b1;
    tick;

    // Prefill all 64 words (R7 path)
    for (int k = 0; k < 16; k++) issue(0, 1, 16'(k * 16), 16, pat(k), junk);

    // R7: a write alone never answers, even with accept high
    fill_accept = 1'b1;
    issue(0, 1, 16'h0040, 16, pat(100), junk);
    quiet_for(LAT + 3, "R7");

    // R1/R11/R2: exact latency, full address returned, removal on pop
    issue(1, 0, 16'h0043, 16, '0, cap);
    repeat (LAT - 1) tick;
    chk(!fill_valid, "R1", "valid one cycle early", 128'(fill_valid), '0);
    tick;
    chk(fill_valid, "R1", "valid at latency", 128'(fill_valid), 128'(1));
    chk(fill_addr == 16'h0043, "R11", "address with low bits", 128'(fill_addr), 128'(16'h0043));
    chk(fill_line == pat(100), "R7", "write visible to read", fill_line, pat(100));
    tick;
    chk(!fill_valid, "R2", "entry removed after pop", 128'(fill_valid), '0);

    // R2/R3: ready read held while accept low
    fill_accept = 1'b0;
    issue(1, 0, 16'h0080, 16, '0, cap);
    quiet_for(LAT + 5, "R3");
    fill_accept = 1'b1;
    expect_resp(16'h0080, cap, "R2");
    #1;
    chk(!fill_valid, "R2", "single response", 128'(fill_valid), '0);

    // R4: oldest first among several ready
    fill_accept = 1'b0;
    ad[0] = 16'h0020; ad[1] = 16'h0010; ad[2] = 16'h0030;
    begin
      logic [127:0] c [3];
      for (int j = 0; j < 3; j++) issue(1, 0, ad[j], 16, '0, c[j]);
      repeat (LAT + 2) tick;
      fill_accept = 1'b1;
      #1;
      for (int j = 0; j < 3; j++) begin
        chk(fill_valid && fill_addr == ad[j], "R4", "order address", 128'(fill_addr), 128'(ad[j]));
        chk(fill_line == c[j], "R4", "order line", fill_line, c[j]);
        tick;
      end
      chk(!fill_valid, "R4", "drained", 128'(fill_valid), '0);
    end

    // R6: capture at acceptance, later write does not alter it
    issue(1, 0, 16'h0050, 16, '0, cap);
    issue(0, 1, 16'h0050, 16, pat(200), junk);
    expect_resp(16'h0050, cap, "R6");
    issue(1, 0, 16'h0050, 16, '0, cap2);
    expect_resp(16'h0050, pat(200), "R6");

    // R8: read+write in one request returns pre-write data, write lands
    issue(1, 1, 16'h0060, 16, pat(300), cap);
    expect_resp(16'h0060, cap, "R8");
    chk(cap != pat(300), "R8", "pre-write differs", cap, pat(300));
    issue(1, 0, 16'h0060, 16, '0, cap2);
    expect_resp(16'h0060, pat(300), "R8");

    // R5: wrap past the top of memory
    issue(0, 1, 16'h00F8, 16, pat(400), junk);
    issue(1, 0, 16'h00F8, 16, '0, cap);
    expect_resp(16'h00F8, pat(400), "R5");
    issue(1, 0, 16'h0000, 8, '0, cap);
    expect_resp(16'h0000, {64'h0, pat(400)[127:64]}, "R5");

    // R5: sweep of sizes, bases and low address bits
    for (int k = 0; k < 24; k++) begin
      int sizes [6] = '{4, 8, 12, 16, 31, 0};
      int sz = sizes[k % 6];
      logic [15:0] a = 16'(((k * 5) % 64) * 4 + (k % 4));
      issue(0, 1, a, sz, pat(500 + k), junk);
      issue(1, 0, a, 16, '0, cap);
      expect_resp(a, cap, "R5");
      issue(1, 0, a, sz, '0, cap);
      expect_resp(a, cap, "R5");
    end

    // R9: fill table, extra read dropped, its write still lands
    fill_accept = 1'b0;
    begin
      logic [127:0] c [4];
      for (int j = 0; j < 4; j++) begin
        ad[j] = 16'(16'h0090 + 16 * j);
        issue(1, 0, ad[j], 16, '0, c[j]);
      end
      #1;
      chk(full, "R9", "full at depth", 128'(full), 128'(1));
      issue(1, 1, 16'h00E0, 16, pat(600), junk);
      repeat (LAT + 2) tick;
      fill_accept = 1'b1;
      #1;
      for (int j = 0; j < 4; j++) begin
        chk(fill_valid && fill_addr == ad[j], "R9", "kept entry", 128'(fill_addr), 128'(ad[j]));
        chk(fill_line == c[j], "R9", "kept line", fill_line, c[j]);
        tick;
      end
      chk(!full, "R9", "full cleared", 128'(full), '0);
      quiet_for(LAT + 3, "R9");
      issue(1, 0, 16'h00E0, 16, '0, cap);
      expect_resp(16'h00E0, pat(600), "R9");
    end

    // R10: reset mid-flight empties table, memory retained
    issue(1, 0, 16'h0070, 16, '0, cap);
    tick; tick;
    rst_n = 1'b0;
    #1;
    chk(!fill_valid && !full && fill_addr == 0, "R10", "async clear",
        {fill_valid, full, fill_addr}, '0);
    tick;
    rst_n = 1'b1;
    quiet_for(LAT + 4, "R10");
    issue(1, 0, 16'h0050, 16, '0, cap);
    expect_resp(16'h0050, pat(200), "R10");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule